// File: doc/BRIEF.md
# JTAG Output Launch Timing Aligner

This block sits between a JTAG shift sequencer and the target pins. It decides when the next TMS and TDI bits reach the target, and it brings TDO samples back. The whole block runs on a fast base-tick clock. The returned test clock reaches it as two single-tick strobes, one for each edge of that clock. Launch timing is measured from the returned clock rather than from the outgoing test clock, so a long isolation path is absorbed by configuration.

Launch timing has three settings. A coarse link delay of 3 to 5 return-clock cycles lets the bits sit in a pipeline. A mode bit chooses whether the rising or the falling return edge triggers the launch; the falling edge adds half a return period. Each of TMS and TDI also has its own fine offset of 0 to 7 base ticks after the triggering edge. TDO is sampled on every rising return edge and goes through a delay line of the same link depth, so each returned bit stays paired with the shift cycle that produced it.

Top module: `jtag_launch_aligner`

## Requirements
- R1: While reset is asserted, `tms_pin` is 1, `tdi_pin` is 0, `tdo_bit` is 0 and `tdo_strb` is 0. Every pipeline stage returns to the idle level of its signal: 1 for TMS, 0 for TDI and 0 for TDO. Launches that occur before enough bits have entered the pipeline therefore drive these idle levels.
- R2: On every base tick where `rck_rise` is 1, the block captures `tms_next`, `tdi_next` and `tdo_pin`. `tdo_strb` is 1 in the tick right after such a strobe and 0 at all other times.
- R3: Let L be the effective link delay. A launch drives the TMS/TDI bit that was captured at the rise strobe L-1 strobes before the most recent rise strobe. If fewer strobes than that have occurred since reset, the launch drives the idle level.
- R4: Link-delay codes below 3 act as 3, and codes above 5 act as 5.
- R5: With `cfg_launch_fall` = 0, only `rck_rise` triggers launches. With `cfg_launch_fall` = 1, only `rck_fall` triggers launches.
- R6: When a launch is triggered in tick t, a signal whose offset is k shows its new value from tick t+1+k onward. TMS uses `cfg_tms_ofs` and TDI uses `cfg_tdi_ofs`, each independently.
- R7: Between launches, `tms_pin` and `tdi_pin` hold their values, whatever happens on `tms_next`, `tdi_next` or the non-selected strobe.
- R8: After each rise strobe, `tdo_bit` shows the `tdo_pin` sample taken L-1 rise strobes earlier. If no such sample exists yet, it shows 0. `tdo_bit` holds that value until the next rise strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base-tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rck_rise | input | 1 | One-tick strobe on each rising edge of the returned clock |
| rck_fall | input | 1 | One-tick strobe on each falling edge of the returned clock |
| tms_next | input | 1 | Next TMS bit from the sequencer |
| tdi_next | input | 1 | Next TDI bit from the sequencer |
| tdo_pin | input | 1 | TDO from the target |
| cfg_launch_fall | input | 1 | 1 selects the falling return edge as the launch trigger |
| cfg_link_dly | input | 3 | Link delay code in return-clock cycles |
| cfg_tms_ofs | input | 3 | Fine offset for TMS in base ticks |
| cfg_tdi_ofs | input | 3 | Fine offset for TDI in base ticks |
| tms_pin | output | 1 | TMS toward the target |
| tdi_pin | output | 1 | TDI toward the target |
| tdo_bit | output | 1 | Delayed TDO sample |
| tdo_strb | output | 1 | Marks a new TDO sample |

## Verification
The bench builds the block with its default parameters: 3-bit offsets and a link range of 3 to 5. This puts every link depth, the two clamp directions and both extreme offsets within reach in short runs. Return-clock periods of 18 base ticks and longer leave room for a full offset of 7 before the next strobe. One odd period is used so that rise-to-fall spacing is asymmetric. Equal offsets on the two signals are also covered.

// File: rtl/jla_pkg.sv
package jla_pkg;

  // Clamp a link-delay code into [lo, hi] and return the pipeline tap index.
  function automatic int link_tap(input int code, input int lo, input int hi);
    int l;
    l = code;
    if (l < lo) l = lo;
    if (l > hi) l = hi;
    return l - 1;
  endfunction

endpackage

// File: rtl/jla_bit_pipe.sv
module jla_bit_pipe #(
  parameter int   DEPTH   = 5,
  parameter int   SEL_W   = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= {DEPTH{RST_VAL}};
    else if (shift_en) stage_q <= {stage_q[DEPTH-2:0], din};
  end

  assign dout = stage_q[sel];

  AST_PIPE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_q[0] == $past(din)); // R2
  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q)); // R2
  AST_PIPE_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel) < DEPTH); // R4

endmodule

// File: rtl/jla_fine_launch.sv
module jla_fine_launch #(
  parameter int   OFS_W   = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [OFS_W-1:0] ofs,
  input  logic             din,
  output logic             pin,
  output logic             fire
);

  logic             armed_q;
  logic [OFS_W-1:0] cnt_q;

  assign fire = armed_q && (cnt_q == '0);

  // A trigger while armed restarts the countdown with the new offset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (trig) begin
      armed_q <= 1'b1;
      cnt_q   <= ofs;
    end else if (fire) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin <= RST_VAL;
    else if (fire) pin <= din;
  end

  // Checker state: ticks elapsed since the last trigger and the offset it carried.
  logic [OFS_W:0]   age_q;
  logic [OFS_W-1:0] ofs_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q      <= '0;
      ofs_seen_q <= '0;
    end else if (trig) begin
      age_q      <= '0;
      ofs_seen_q <= ofs;
    end else if (armed_q) begin
      age_q      <= age_q + 1'b1;
    end
  end

  AST_FIRE_AT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> age_q == {1'b0, ofs_seen_q}); // R6
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pin)); // R7
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !trig) |=> !fire); // R6

endmodule

// File: rtl/jtag_launch_aligner.sv
module jtag_launch_aligner #(
  parameter int OFS_W    = 3,
  parameter int LINK_W   = 3,
  parameter int MIN_LINK = 3,
  parameter int MAX_LINK = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rck_rise,
  input  logic              rck_fall,
  input  logic              tms_next,
  input  logic              tdi_next,
  input  logic              tdo_pin,
  input  logic              cfg_launch_fall,
  input  logic [LINK_W-1:0] cfg_link_dly,
  input  logic [OFS_W-1:0]  cfg_tms_ofs,
  input  logic [OFS_W-1:0]  cfg_tdi_ofs,
  output logic              tms_pin,
  output logic              tdi_pin,
  output logic              tdo_bit,
  output logic              tdo_strb
);

  localparam int TAP_W = (MAX_LINK > 1) ? $clog2(MAX_LINK) : 1;
  // Lane order: 0 = TMS, 1 = TDI, 2 = TDO; bit value is the lane's idle level.
  localparam logic [2:0] LANE_IDLE = 3'b001;

  logic [TAP_W-1:0] tap_sel;
  logic             launch_trig;
  logic [2:0]       lane_din;
  logic [2:0]       lane_tap;
  logic [1:0]       lane_pin;
  logic [1:0]       lane_fire;
  logic [1:0][OFS_W-1:0] lane_ofs;

  assign tap_sel     = TAP_W'(jla_pkg::link_tap(int'(cfg_link_dly), MIN_LINK, MAX_LINK));
  assign launch_trig = cfg_launch_fall ? rck_fall : rck_rise;
  assign lane_din    = {tdo_pin, tdi_next, tms_next};
  assign lane_ofs    = {cfg_tdi_ofs, cfg_tms_ofs};

  for (genvar gi = 0; gi < 3; gi++) begin : g_lane_pipe
    jla_bit_pipe #(
      .DEPTH  (MAX_LINK),
      .SEL_W  (TAP_W),
      .RST_VAL(LANE_IDLE[gi])
    ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(rck_rise),
      .din     (lane_din[gi]),
      .sel     (tap_sel),
      .dout    (lane_tap[gi])
    );
  end

  for (genvar gl = 0; gl < 2; gl++) begin : g_launch
    jla_fine_launch #(
      .OFS_W  (OFS_W),
      .RST_VAL(LANE_IDLE[gl])
    ) u_launch (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (launch_trig),
      .ofs  (lane_ofs[gl]),
      .din  (lane_tap[gl]),
      .pin  (lane_pin[gl]),
      .fire (lane_fire[gl])
    );
  end

  assign tms_pin = lane_pin[0];
  assign tdi_pin = lane_pin[1];
  assign tdo_bit = lane_tap[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdo_strb <= 1'b0;
    else        tdo_strb <= rck_rise;
  end

  AST_STRB_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rck_rise |=> tdo_strb); // R2
  AST_STRB_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rck_rise |=> !tdo_strb); // R2
  AST_TMS_LAUNCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fire[0] |=> tms_pin == $past(lane_tap[0])); // R3
  AST_TDI_LAUNCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fire[1] |=> tdi_pin == $past(lane_tap[1])); // R3
  AST_TDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rck_rise && $stable(cfg_link_dly)) |=> $stable(tdo_bit)); // R8

endmodule

// File: tb/jtag_launch_aligner_test.sv
module jtag_launch_aligner_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rck_rise = 1'b0, rck_fall = 1'b0;
  logic       tms_next = 1'b0, tdi_next = 1'b0, tdo_pin = 1'b0;
  logic       cfg_launch_fall = 1'b0;
  logic [2:0] cfg_link_dly = 3'd3, cfg_tms_ofs = 3'd0, cfg_tdi_ofs = 3'd0;
  logic       tms_pin, tdi_pin, tdo_bit, tdo_strb;

  int total = 0, fails = 0;
  bit done = 0;
  string ptag = "R1";

  always #(CLK_P/2) clk = ~clk;

  jtag_launch_aligner uut (
    .clk(clk), .rst_n(rst_n), .rck_rise(rck_rise), .rck_fall(rck_fall),
    .tms_next(tms_next), .tdi_next(tdi_next), .tdo_pin(tdo_pin),
    .cfg_launch_fall(cfg_launch_fall), .cfg_link_dly(cfg_link_dly),
    .cfg_tms_ofs(cfg_tms_ofs), .cfg_tdi_ofs(cfg_tdi_ofs),
    .tms_pin(tms_pin), .tdi_pin(tdi_pin), .tdo_bit(tdo_bit), .tdo_strb(tdo_strb));

  // Reference model state
  bit tms_h[$], tdi_h[$], tdo_h[$];
  int n_rise = 0;
  int cnt_t = -1, cnt_d = -1;
  bit e_tms = 1'b1, e_tdi = 1'b0, e_strb = 1'b0;

  function automatic int eff_link(input int code);
    if (code < 3) return 3;
    if (code > 5) return 5;
    return code;
  endfunction

  function automatic bit pick(input bit q[$], input int n, input int lnk, input bit idle);
    int idx;
    idx = n - lnk;
    if (idx < 0) return idle;
    return q[idx];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      tms_h.delete(); tdi_h.delete(); tdo_h.delete();
      n_rise = 0; cnt_t = -1; cnt_d = -1;
      e_tms = 1'b1; e_tdi = 1'b0; e_strb = 1'b0;
    end else begin
      int lnk;
      bit trig;
      lnk  = eff_link(int'(cfg_link_dly));
      trig = cfg_launch_fall ? rck_fall : rck_rise;
      if (cnt_t == 0) e_tms = pick(tms_h, n_rise, lnk, 1'b1);
      if (cnt_d == 0) e_tdi = pick(tdi_h, n_rise, lnk, 1'b0);
      if (trig) cnt_t = int'(cfg_tms_ofs);
      else if (cnt_t >= 0) cnt_t = cnt_t - 1;
      if (trig) cnt_d = int'(cfg_tdi_ofs);
      else if (cnt_d >= 0) cnt_d = cnt_d - 1;
      e_strb = rck_rise;
      if (rck_rise) begin
        tms_h.push_back(tms_next);
        tdi_h.push_back(tdi_next);
        tdo_h.push_back(tdo_pin);
        n_rise++;
      end
    end
  end

  task automatic chk(input string req, input string what, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", req, what, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(ptag, "tms_pin", tms_pin, e_tms);
    chk(ptag, "tdi_pin", tdi_pin, e_tdi);
    chk("R8", "tdo_bit", tdo_bit, pick(tdo_h, n_rise, eff_link(int'(cfg_link_dly)), 1'b0));
    chk("R2", "tdo_strb", tdo_strb, e_strb);
  endtask

  task automatic tick(input bit r, input bit f);
    @(negedge clk);
    compare();
    rck_rise = r;
    rck_fall = f;
    tms_next = 1'($urandom);
    tdi_next = 1'($urandom);
    tdo_pin  = 1'($urandom);
  endtask

  task automatic run(input int per, input int cycles);
    for (int c = 0; c < cycles; c++) tick((c % per) == 0, (c % per) == per/2);
    tick(1'b0, 1'b0);
  endtask

  task automatic phase(input string tag, input bit fall, input int link,
                       input int ot, input int od, input int per, input int rcycles);
    @(negedge clk);
    rst_n = 1'b0;
    rck_rise = 1'b0; rck_fall = 1'b0;
    cfg_launch_fall = fall;
    cfg_link_dly = 3'(link);
    cfg_tms_ofs = 3'(ot);
    cfg_tdi_ofs = 3'(od);
    ptag = "R1";
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    ptag = tag;
    run(per, per * rcycles);
  endtask

  initial begin
    // R1: reset levels, then R7: no strobes means pins hold their idle levels
    ptag = "R1";
    repeat (4) tick(1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    ptag = "R7";
    repeat (20) tick(1'b0, 1'b0);
    phase("R3", 1'b0, 3, 0, 7, 18, 30);  // shortest link, extreme offsets
    phase("R6", 1'b0, 4, 3, 1, 24, 30);  // distinct per-signal offsets
    phase("R5", 1'b1, 5, 2, 6, 20, 30);  // falling-edge launch
    phase("R4", 1'b1, 0, 7, 0, 18, 25);  // code 0 clamps to 3
    phase("R4", 1'b0, 7, 1, 4, 22, 25);  // code 7 clamps to 5
    phase("R7", 1'b0, 4, 5, 5, 31, 25);  // odd period, equal offsets
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule